// File: doc/BRIEF.md
# Paired Stochastic Bitstream Encoder with Correlation Control

This block turns two 8-bit values into two serial unary bitstreams. In each bit slot every lane emits a 1 with probability value/256. A lane compares a pseudo-random byte with its value and emits a 1 when the byte is smaller. Downstream stochastic logic consumes the two streams bit by bit: an AND gate multiplies two independent streams, and an XOR gate subtracts two fully overlapping streams.

The relation between the two streams is chosen per request:
- **Independent:** each lane has its own random generator, so the lanes are statistically independent.
- **Overlapping:** both lanes compare against the same random byte, so their 1s overlap as much as the two densities allow.
- **Anti-overlapping:** the second lane compares against the bitwise complement of that byte, so its 1s fill the first lane's 0 slots first.

A one-cycle start pulse does three things. It latches both values, the mode and the stream length. It reloads both generators with fixed seeds, so the same request always gives the same streams. Then exactly the requested number of bits is emitted on consecutive cycles, and a done pulse follows.

Top module: `sc_pair_encoder`

## Requirements
- R1: After reset, bit_a, bit_b, bit_vld and done are all 0 until a stream is requested.
- R2: A start pulse with a nonzero stream_len L is sampled on a clock edge. bit_vld is high on the next L consecutive cycles, starting with the cycle after the second rising edge.
- R3: done is high for exactly one cycle, the cycle right after the last valid bit; it is never high while bit_vld is high.
- R4: bit_a and bit_b are 0 in every cycle in which bit_vld is 0, in every mode.
- R5: A lane bit is 1 exactly when its random byte is below the lane value. A value of 0 never yields a 1, and over 256 bits the count of 1s lies within 32 of the value.
- R6: corr_mode encoding is 2'b00 independent, 2'b01 overlapping, 2'b10 anti-overlapping and 2'b11 independent. In the independent modes, equal values still give differing streams.
- R7: In overlapping mode, every 1 of the lane with the smaller value is matched by a 1 in the other lane; equal values give identical streams.
- R8: In anti-overlapping mode, both lanes are never 1 together if value_a+value_b <= 256, and never 0 together if value_a+value_b >= 256. A sum of exactly 256 gives bit_b equal to the inverse of bit_a in every valid slot.
- R9: Each accepted start reloads the generator seeds, so repeating a request reproduces the same pair of streams bit for bit.
- R10: A start with stream_len 0 is ignored: no valid bit and no done follow it.
- R11: A start during a running stream restarts it. The bit already in flight is emitted, then exactly the new length follows, and only the new stream reports done.
- R12: Values, mode and length are latched at start; changing the inputs while a stream runs leaves that stream unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a stream |
| stream_len | input | LEN_W (9) | Number of bits to emit; 0 means no request |
| corr_mode | input | 2 | 00/11 independent, 01 overlapping, 10 anti-overlapping |
| value_a | input | VAL_W (8) | Density numerator for lane A (out of 256) |
| value_b | input | VAL_W (8) | Density numerator for lane B (out of 256) |
| bit_a | output | 1 | Lane A stream bit |
| bit_b | output | 1 | Lane B stream bit |
| bit_vld | output | 1 | Marks a valid bit slot |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
Value pairs are driven in each mode with the smaller value on either lane, with equal values, and with anti-overlapping sums below, equal to and above 256. These patterns separate a shared random byte from a complemented one and from a separate generator. The extremes 0 and 255 and the lengths 4, 16, 64, 100 and 256 test the density rule and the slot count. Repeated, restarted, zero-length and input-scrambled requests test seeding, restart handling and input latching.

// File: rtl/sc_enc_pkg.sv
package sc_enc_pkg;
  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_POS  = 2'b01,
    MODE_NEG  = 2'b10,
    MODE_IND2 = 2'b11
  } corr_mode_t;
endpackage

// File: rtl/sc_lfsr.sv
// Galois generator; exposes only its top OUT_W bits as the random sample.
module sc_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 8,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  output logic [OUT_W-1:0] sample
);
  logic [W-1:0] state;
  logic [W-1:0] nxt;

  always_comb nxt = {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (rst || load) state <= SEED;
    else if (step)   state <= nxt;
  end

  assign sample = state[W-1 -: OUT_W];

  // R9: a seeded maximal generator never reaches the all-zero lock state
  a_r9_state_nonzero: assert property (@(posedge clk) disable iff (rst) state != '0);
endmodule

// File: rtl/sc_lane.sv
// One comparator lane with a registered, slot-gated output bit.
module sc_lane #(
  parameter int VAL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic [VAL_W-1:0] sample,
  input  logic [VAL_W-1:0] value,
  output logic             bit_o
);
  always_ff @(posedge clk) begin
    if (rst) bit_o <= 1'b0;
    else     bit_o <= emit && (sample < value);
  end

  // R5: a zero value can never produce a 1
  a_r5_zero_never_one: assert property (@(posedge clk) disable iff (rst)
    (value == '0 && $past(value) == '0 && !$past(rst)) |-> !bit_o);
endmodule

// File: rtl/sc_seq.sv
// Slot counter: accepts requests, paces the bit slots, raises done.
module sc_seq #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             accept,
  output logic             busy,
  output logic             vld,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             fin;

  assign accept = start && (len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
      vld   <= 1'b0;
      fin   <= 1'b0;
      done  <= 1'b0;
    end else begin
      vld  <= busy;
      done <= fin;
      fin  <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        cnt   <= '0;
        len_q <= len;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == len_q - 1'b1) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // R2: the slot counter stays inside the programmed length
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst) busy |-> cnt < len_q);
  // R3: done follows a valid slot and lasts one cycle
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> (!vld && $past(vld)));
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

// File: rtl/sc_pair_encoder.sv
module sc_pair_encoder
  import sc_enc_pkg::*;
#(
  parameter int          VAL_W  = 8,
  parameter int          LEN_W  = 9,
  parameter int          RNG_W  = 16,
  parameter logic [RNG_W-1:0] TAPS   = 16'hB400,
  parameter logic [RNG_W-1:0] SEED_A = 16'hACE1,
  parameter logic [RNG_W-1:0] SEED_B = 16'h5D3B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] stream_len,
  input  logic [1:0]       corr_mode,
  input  logic [VAL_W-1:0] value_a,
  input  logic [VAL_W-1:0] value_b,
  output logic             bit_a,
  output logic             bit_b,
  output logic             bit_vld,
  output logic             done
);
  localparam int LANES = 2;

  logic             accept, busy;
  corr_mode_t       mode_q;
  logic [VAL_W-1:0] val_q  [LANES];
  logic [VAL_W-1:0] rnd    [LANES];
  logic [VAL_W-1:0] smp    [LANES];
  logic             lane_bit [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IND;
      val_q[0] <= '0;
      val_q[1] <= '0;
    end else if (accept) begin
      mode_q   <= corr_mode_t'(corr_mode);
      val_q[0] <= value_a;
      val_q[1] <= value_b;
    end
  end

  sc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .len(stream_len),
    .accept(accept), .busy(busy), .vld(bit_vld), .done(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sc_lfsr #(.W(RNG_W), .OUT_W(VAL_W), .TAPS(TAPS),
              .SEED(g == 0 ? SEED_A : SEED_B)) u_rng (
      .clk(clk), .rst(rst), .load(accept), .step(busy), .sample(rnd[g])
    );
    sc_lane #(.VAL_W(VAL_W)) u_lane (
      .clk(clk), .rst(rst), .emit(busy), .sample(smp[g]),
      .value(val_q[g]), .bit_o(lane_bit[g])
    );
  end

  // Lane A always uses its own generator; lane B's source follows the mode.
  always_comb begin
    smp[0] = rnd[0];
    case (mode_q)
      MODE_POS: smp[1] = rnd[0];
      MODE_NEG: smp[1] = ~rnd[0];
      default:  smp[1] = rnd[1];
    endcase
  end

  assign bit_a = lane_bit[0];
  assign bit_b = lane_bit[1];

  // R4: no stray 1s outside valid slots
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> (!bit_a && !bit_b));
  // R7: overlapping mode nests the smaller stream in the larger one
  a_r7_pos_nested: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && $past(mode_q) == MODE_POS && $past(val_q[0]) <= $past(val_q[1]))
      |-> !(bit_a && !bit_b));
  // R8: anti-overlapping mode with sum 256 gives exact complements
  a_r8_neg_complement: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && $past(mode_q) == MODE_NEG &&
     ({1'b0, $past(val_q[0])} + {1'b0, $past(val_q[1])}) == 9'd256)
      |-> (bit_a != bit_b));
endmodule

// File: tb/sc_pair_encoder_test.sv
module sc_pair_encoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [8:0] stream_len = '0;
  logic [1:0] corr_mode = '0;
  logic [7:0] value_a = '0, value_b = '0;
  logic       bit_a, bit_b, bit_vld, done;

  always #5 clk = ~clk;

  sc_pair_encoder uut (
    .clk(clk), .rst(rst), .start(start), .stream_len(stream_len),
    .corr_mode(corr_mode), .value_a(value_a), .value_b(value_b),
    .bit_a(bit_a), .bit_b(bit_b), .bit_vld(bit_vld), .done(done)
  );

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fields: mode[26:25] va[24:17] vb[16:9] len[8:0]
  localparam int NV = 13;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'd64,  8'd192, 9'd256},
    {2'd0, 8'd128, 8'd128, 9'd256},
    {2'd1, 8'd64,  8'd192, 9'd256},
    {2'd1, 8'd200, 8'd50,  9'd256},
    {2'd1, 8'd128, 8'd128, 9'd256},
    {2'd2, 8'd100, 8'd156, 9'd256},
    {2'd2, 8'd60,  8'd90,  9'd256},
    {2'd2, 8'd200, 8'd180, 9'd256},
    {2'd0, 8'd0,   8'd255, 9'd256},
    {2'd1, 8'd77,  8'd33,  9'd4},
    {2'd2, 8'd10,  8'd20,  9'd16},
    {2'd3, 8'd128, 8'd128, 9'd64},
    {2'd1, 8'd90,  8'd90,  9'd100}
  };

  int na, nb, n11, n00, nv, nd, first_v, done_idx, idle_bad, a_only, b_only, diff;
  int unsigned sig;

  task automatic clear_stats();
    na = 0; nb = 0; n11 = 0; n00 = 0; nv = 0; nd = 0; first_v = -1; done_idx = -1;
    idle_bad = 0; a_only = 0; b_only = 0; diff = 0; sig = 32'h1;
  endtask

  task automatic sample_cycle(input int i);
    if (bit_vld) begin
      nv++;
      if (first_v < 0) first_v = i;
      if (bit_a) na++;
      if (bit_b) nb++;
      if (bit_a && bit_b) n11++;
      if (!bit_a && !bit_b) n00++;
      if (bit_a && !bit_b) a_only++;
      if (!bit_a && bit_b) b_only++;
      if (bit_a != bit_b) diff++;
      sig = sig * 32'd31 + {30'd0, bit_a, bit_b} + 32'd7;
    end else if (bit_a || bit_b) idle_bad++;
    if (done) begin nd++; if (done_idx < 0) done_idx = i; end
  endtask

  task automatic run(input logic [1:0] m, input logic [7:0] va, input logic [7:0] vb,
                     input int len, input bit scramble);
    clear_stats();
    @(negedge clk);
    corr_mode = m; value_a = va; value_b = vb; stream_len = 9'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      corr_mode = 2'd2; value_a = 8'd0; value_b = 8'd255; stream_len = 9'd0;
    end
    for (int i = 0; i <= len + 3; i++) begin
      if (i > 0) @(negedge clk);
      sample_cycle(i);
    end
  endtask

  int unsigned ref_sig;
  int          ref_na;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bit_a && !bit_b && !bit_vld && !done, "R1 outputs in reset", int'({bit_a, bit_b, bit_vld, done}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bit_a && !bit_b && !bit_vld && !done, "R1 idle after reset", int'({bit_a, bit_b, bit_vld, done}), 0);

    for (int k = 0; k < NV; k++) begin
      logic [1:0] m;
      int va, vb, len;
      m = VEC[k][26:25]; va = int'(VEC[k][24:17]); vb = int'(VEC[k][16:9]); len = int'(VEC[k][8:0]);
      run(m, 8'(va), 8'(vb), len, 1'b0);
      chk(nv == len, "R2 valid slot count", nv, len);
      chk(first_v == 1, "R2 first valid slot", first_v, 1);
      chk(nd == 1 && done_idx == len + 1, "R3 done position", done_idx, len + 1);
      chk(idle_bad == 0, "R4 bits outside slots", idle_bad, 0);
      if (va == 0) chk(na == 0, "R5 zero value lane A", na, 0);
      if (len == 256) begin
        chk(na >= va - 32 && na <= va + 32, "R5 lane A density", na, va);
        chk(nb >= vb - 32 && nb <= vb + 32, "R5 lane B density", nb, vb);
      end
      if (m == 2'd0 || m == 2'd3) begin
        if (va == vb) chk(diff > 0, "R6 independent streams differ", diff, 1);
      end else if (m == 2'd1) begin
        if (va <= vb) chk(a_only == 0, "R7 smaller stream nested (A)", a_only, 0);
        if (vb <= va) chk(b_only == 0, "R7 smaller stream nested (B)", b_only, 0);
      end else begin
        if (va + vb <= 256) chk(n11 == 0, "R8 no shared ones", n11, 0);
        if (va + vb >= 256) chk(n00 == 0, "R8 no shared zeros", n00, 0);
        if (va + vb == 256) chk(diff == len, "R8 exact complement", diff, len);
      end
    end

    // R9: seeds reload on every start
    run(2'd0, 8'd64, 8'd192, 256, 1'b0);
    ref_sig = sig; ref_na = na;
    run(2'd1, 8'd30, 8'd40, 16, 1'b0);
    run(2'd0, 8'd64, 8'd192, 256, 1'b0);
    chk(sig == ref_sig, "R9 repeat reproduces stream", na, ref_na);

    // R12: inputs changed mid-stream have no effect
    run(2'd0, 8'd64, 8'd192, 256, 1'b1);
    chk(sig == ref_sig && nv == 256, "R12 latched request", na, ref_na);

    // R10: zero length is ignored
    clear_stats();
    @(negedge clk);
    corr_mode = 2'd1; value_a = 8'd200; value_b = 8'd200; stream_len = 9'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      sample_cycle(i);
    end
    chk(nv == 0 && nd == 0, "R10 zero length ignored", nv + nd, 0);

    // R11: restart during a stream
    clear_stats();
    @(negedge clk);
    corr_mode = 2'd0; value_a = 8'd100; value_b = 8'd100; stream_len = 9'd64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= 34; i++) begin
      if (i > 0) @(negedge clk);
      sample_cycle(i);
      if (i == 10) begin stream_len = 9'd16; start = 1'b1; end
      if (i == 11) start = 1'b0;
    end
    chk(nv == 27, "R11 slots across restart", nv, 27);
    chk(nd == 1 && done_idx == 28, "R11 single done after new length", done_idx, 28);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule